// File: doc/BRIEF.md
# GMII to RGMII Bridge

This block sits between a byte-wide media access controller and a reduced-pin gigabit physical-layer device. On the transmit side it takes an 8-bit data byte, a transmit enable and a transmit error strobe, all sampled on the rising edge of a 125 MHz clock. It emits them as a 4-bit nibble bus and a single control line that change on both clock edges, plus a forwarded copy of the clock. The low nibble goes out while the clock is high and the high nibble goes out while it is low. The control line carries the enable in the first half of the cycle and the enable XOR error in the second half.

On the receive side it samples a 4-bit nibble bus and a control line on both edges of the receive clock. It then rebuilds a byte, a data-valid strobe and an error strobe, and presents them on the next rising edge. The receive clock is assumed to be already shifted by a quarter period, so that both edges fall mid-eye. That shift is done outside this block.

Top module: `gmii_rgmii_bridge`

## Requirements
- R1: While the synchronous active-high reset is applied, the transmit nibble bus, the transmit control line and all three receive byte-side outputs read zero.
- R2: Data bits 3:0 captured at a rising edge appear on the transmit nibble bus during the high phase that immediately follows that edge.
- R3: Data bits 7:4 captured at the same rising edge appear on the transmit nibble bus during the low phase of that same cycle.
- R4: During the high phase, the transmit control line equals the captured enable.
- R5: During the low phase, the transmit control line equals the captured enable XOR the captured error (1 for a clean byte, 0 for an errored byte).
- R6: When the captured enable is 0, the nibble bus and the control line are 0 in both phases, whatever the data and error inputs hold.
- R7: The forwarded transmit clock is high in the high phase of the core clock and low in its low phase.
- R8: The received byte is {falling-edge nibble, rising-edge nibble} of one receive cycle, and is presented at the next rising edge of the receive clock.
- R9: The received data-valid output equals the control line sampled at the rising edge of the same receive cycle.
- R10: The received error output equals the XOR of the rising-edge and falling-edge control samples of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz core and transmit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| gmii_txd_i | input | 8 | Transmit byte from the MAC |
| gmii_tx_en_i | input | 1 | Transmit enable from the MAC |
| gmii_tx_er_i | input | 1 | Transmit error from the MAC |
| rgmii_txc_o | output | 1 | Forwarded transmit clock |
| rgmii_txd_o | output | 4 | Double-rate transmit nibble bus |
| rgmii_tx_ctl_o | output | 1 | Double-rate transmit control line |
| rgmii_rxc_i | input | 1 | Receive clock, already shifted to mid-eye |
| rgmii_rxd_i | input | 4 | Double-rate receive nibble bus |
| rgmii_rx_ctl_i | input | 1 | Double-rate receive control line |
| gmii_rxd_o | output | 8 | Reassembled receive byte |
| gmii_rx_dv_o | output | 1 | Receive data valid |
| gmii_rx_er_o | output | 1 | Receive error |

## Verification
The assertions check on every edge that each half-cycle of the transmit bus matches the byte and strobes captured at the preceding rising edge, including the all-zero idle encoding. They also check that every received byte and strobe pair matches the pin samples taken two edges and one falling edge earlier. The reset values, the forwarded clock and the behaviour across distinct traffic mixes can only be shown by the bench's scenarios. Those mixes are clean frames, idle with garbage on data and error, errored frames, false-carrier receive cycles and random interleavings.

// File: rtl/gmii_rgmii_pkg.sv
`timescale 1ns/1ps
package gmii_rgmii_pkg;

  // default nibble width of the double-rate side
  localparam int unsigned NIB_W_DEF = 4;

  // second-half control code: enable XOR error, forced low while idle
  function automatic logic tx_ctl_second(input logic en, input logic er);
    return en ? ~er : 1'b0;
  endfunction

  // error recovered from the two control samples of one cycle
  function automatic logic rx_err_from_ctl(input logic first, input logic second);
    return first ^ second;
  endfunction

endpackage

// File: rtl/gr_tx_encode.sv
`timescale 1ns/1ps
module gr_tx_encode #(
  parameter int unsigned NIB_W = gmii_rgmii_pkg::NIB_W_DEF,
  localparam int unsigned BYTE_W = 2 * NIB_W,
  localparam int unsigned HALF_W = NIB_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [BYTE_W-1:0] txd_i,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  output logic [HALF_W-1:0] rise_o,
  output logic [HALF_W-1:0] fall_o
);
  import gmii_rgmii_pkg::*;

  // {ctl, nibble} for each half cycle, registered on the rising edge
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rise_o <= '0;
      fall_o <= '0;
    end else if (tx_en_i) begin
      rise_o <= {1'b1, txd_i[NIB_W-1:0]};
      fall_o <= {tx_ctl_second(tx_en_i, tx_er_i), txd_i[BYTE_W-1:NIB_W]};
    end else begin
      rise_o <= '0;
      fall_o <= '0;
    end
  end

endmodule

// File: rtl/gr_ddr_out.sv
`timescale 1ns/1ps
module gr_ddr_out #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] pin_o
);

  logic [W-1:0] fall_q;

  // second half is retimed to the falling edge so it is stable for the whole low phase
  always_ff @(negedge clk_i) begin
    if (rst_i) fall_q <= '0;
    else       fall_q <= fall_i;
  end

  // per-bit output selector, high phase carries the first half
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign pin_o[b] = clk_i ? rise_i[b] : fall_q[b];
  end

endmodule

// File: rtl/gr_ddr_in.sv
`timescale 1ns/1ps
module gr_ddr_in #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) rise_o <= '0;
    else       rise_o <= pin_i;
  end

  always_ff @(negedge clk_i) begin
    if (rst_i) fall_o <= '0;
    else       fall_o <= pin_i;
  end

endmodule

// File: rtl/gr_rx_decode.sv
`timescale 1ns/1ps
module gr_rx_decode #(
  parameter int unsigned NIB_W = gmii_rgmii_pkg::NIB_W_DEF,
  localparam int unsigned BYTE_W = 2 * NIB_W,
  localparam int unsigned HALF_W = NIB_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [HALF_W-1:0] rise_i,
  input  logic [HALF_W-1:0] fall_i,
  output logic [BYTE_W-1:0] rxd_o,
  output logic              dv_o,
  output logic              er_o
);
  import gmii_rgmii_pkg::*;

  // both samples of one cycle are complete here, realign to the rising edge
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rxd_o <= '0;
      dv_o  <= 1'b0;
      er_o  <= 1'b0;
    end else begin
      rxd_o <= {fall_i[NIB_W-1:0], rise_i[NIB_W-1:0]};
      dv_o  <= rise_i[NIB_W];
      er_o  <= rx_err_from_ctl(rise_i[NIB_W], fall_i[NIB_W]);
    end
  end

endmodule

// File: rtl/gmii_rgmii_bridge.sv
`timescale 1ns/1ps
module gmii_rgmii_bridge #(
  parameter int unsigned NIB_W = gmii_rgmii_pkg::NIB_W_DEF,
  localparam int unsigned BYTE_W = 2 * NIB_W,
  localparam int unsigned HALF_W = NIB_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [BYTE_W-1:0] gmii_txd_i,
  input  logic              gmii_tx_en_i,
  input  logic              gmii_tx_er_i,
  output logic              rgmii_txc_o,
  output logic [NIB_W-1:0]  rgmii_txd_o,
  output logic              rgmii_tx_ctl_o,
  input  logic              rgmii_rxc_i,
  input  logic [NIB_W-1:0]  rgmii_rxd_i,
  input  logic              rgmii_rx_ctl_i,
  output logic [BYTE_W-1:0] gmii_rxd_o,
  output logic              gmii_rx_dv_o,
  output logic              gmii_rx_er_o
);

  logic [HALF_W-1:0] tx_rise, tx_fall, tx_pins;
  logic [HALF_W-1:0] rx_rise, rx_fall;

  gr_tx_encode #(.NIB_W(NIB_W)) u_tx_enc (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .txd_i   (gmii_txd_i),
    .tx_en_i (gmii_tx_en_i),
    .tx_er_i (gmii_tx_er_i),
    .rise_o  (tx_rise),
    .fall_o  (tx_fall)
  );

  gr_ddr_out #(.W(HALF_W)) u_tx_ddr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .rise_i (tx_rise),
    .fall_i (tx_fall),
    .pin_o  (tx_pins)
  );

  assign rgmii_txd_o    = tx_pins[NIB_W-1:0];
  assign rgmii_tx_ctl_o = tx_pins[NIB_W];
  assign rgmii_txc_o    = clk_i;

  gr_ddr_in #(.W(HALF_W)) u_rx_ddr (
    .clk_i  (rgmii_rxc_i),
    .rst_i  (rst_i),
    .pin_i  ({rgmii_rx_ctl_i, rgmii_rxd_i}),
    .rise_o (rx_rise),
    .fall_o (rx_fall)
  );

  gr_rx_decode #(.NIB_W(NIB_W)) u_rx_dec (
    .clk_i  (rgmii_rxc_i),
    .rst_i  (rst_i),
    .rise_i (rx_rise),
    .fall_i (rx_fall),
    .rxd_o  (gmii_rxd_o),
    .dv_o   (gmii_rx_dv_o),
    .er_o   (gmii_rx_er_o)
  );

endmodule

// File: rtl/gmii_rgmii_bridge_chk.sv
`timescale 1ns/1ps
module gmii_rgmii_bridge_chk #(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BYTE_W = 2 * NIB_W
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [BYTE_W-1:0] gmii_txd_i,
  input logic              gmii_tx_en_i,
  input logic              gmii_tx_er_i,
  input logic              rgmii_txc_o,
  input logic [NIB_W-1:0]  rgmii_txd_o,
  input logic              rgmii_tx_ctl_o,
  input logic              rgmii_rxc_i,
  input logic [NIB_W-1:0]  rgmii_rxd_i,
  input logic              rgmii_rx_ctl_i,
  input logic [BYTE_W-1:0] gmii_rxd_o,
  input logic              gmii_rx_dv_o,
  input logic              gmii_rx_er_o
);

  logic [BYTE_W-1:0] cap_d;
  logic              cap_en, cap_er;
  logic [NIB_W-1:0]  smp_fall_d;
  logic              smp_fall_ctl;
  logic [1:0]        rx_age;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cap_d  <= '0;
      cap_en <= 1'b0;
      cap_er <= 1'b0;
    end else begin
      cap_d  <= gmii_txd_i;
      cap_en <= gmii_tx_en_i;
      cap_er <= gmii_tx_er_i;
    end
  end

  always_ff @(negedge rgmii_rxc_i) begin
    if (rst_i) begin
      smp_fall_d   <= '0;
      smp_fall_ctl <= 1'b0;
    end else begin
      smp_fall_d   <= rgmii_rxd_i;
      smp_fall_ctl <= rgmii_rx_ctl_i;
    end
  end

  always_ff @(posedge rgmii_rxc_i) begin
    if (rst_i)               rx_age <= '0;
    else if (rx_age != 2'd3) rx_age <= rx_age + 2'd1;
  end

  // R2 R4
  tx_first_half_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    cap_en |-> (rgmii_txd_o == cap_d[NIB_W-1:0] && rgmii_tx_ctl_o));

  // R3 R5
  tx_second_half_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cap_en |-> (rgmii_txd_o == cap_d[BYTE_W-1:NIB_W] && rgmii_tx_ctl_o == !cap_er));

  // R6
  tx_idle_first_chk: assert property (@(negedge clk_i) disable iff (rst_i)
    !cap_en |-> (rgmii_txd_o == '0 && !rgmii_tx_ctl_o));

  // R6
  tx_idle_second_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !cap_en |-> (rgmii_txd_o == '0 && !rgmii_tx_ctl_o));

  // R8
  rx_byte_chk: assert property (@(posedge rgmii_rxc_i) disable iff (rst_i)
    (rx_age >= 2'd2) |-> (gmii_rxd_o == {$past(smp_fall_d), $past(rgmii_rxd_i, 2)}));

  // R9
  rx_valid_chk: assert property (@(posedge rgmii_rxc_i) disable iff (rst_i)
    (rx_age >= 2'd2) |-> (gmii_rx_dv_o == $past(rgmii_rx_ctl_i, 2)));

  // R10
  rx_error_chk: assert property (@(posedge rgmii_rxc_i) disable iff (rst_i)
    (rx_age >= 2'd2) |-> (gmii_rx_er_o == ($past(rgmii_rx_ctl_i, 2) ^ $past(smp_fall_ctl))));

endmodule

bind gmii_rgmii_bridge gmii_rgmii_bridge_chk #(.NIB_W(NIB_W)) u_chk (
  .clk_i          (clk_i),
  .rst_i          (rst_i),
  .gmii_txd_i     (gmii_txd_i),
  .gmii_tx_en_i   (gmii_tx_en_i),
  .gmii_tx_er_i   (gmii_tx_er_i),
  .rgmii_txc_o    (rgmii_txc_o),
  .rgmii_txd_o    (rgmii_txd_o),
  .rgmii_tx_ctl_o (rgmii_tx_ctl_o),
  .rgmii_rxc_i    (rgmii_rxc_i),
  .rgmii_rxd_i    (rgmii_rxd_i),
  .rgmii_rx_ctl_i (rgmii_rx_ctl_i),
  .gmii_rxd_o     (gmii_rxd_o),
  .gmii_rx_dv_o   (gmii_rx_dv_o),
  .gmii_rx_er_o   (gmii_rx_er_o)
);

// File: tb/gmii_rgmii_bridge_tb_top.sv
`timescale 1ns/1ps
module gmii_rgmii_bridge_tb_top;

  localparam int NCYC = 600;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] txd;
  logic       tx_en, tx_er;
  logic       txc;
  logic [3:0] r_txd;
  logic       r_txctl;
  logic [3:0] r_rxd;
  logic       r_rxctl;
  logic [7:0] rxd;
  logic       rx_dv, rx_er;

  always #10 clk = ~clk;

  gmii_rgmii_bridge dut_i (
    .clk_i          (clk),
    .rst_i          (rst),
    .gmii_txd_i     (txd),
    .gmii_tx_en_i   (tx_en),
    .gmii_tx_er_i   (tx_er),
    .rgmii_txc_o    (txc),
    .rgmii_txd_o    (r_txd),
    .rgmii_tx_ctl_o (r_txctl),
    .rgmii_rxc_i    (clk),
    .rgmii_rxd_i    (r_rxd),
    .rgmii_rx_ctl_i (r_rxctl),
    .gmii_rxd_o     (rxd),
    .gmii_rx_dv_o   (rx_dv),
    .gmii_rx_er_o   (rx_er)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // transmit model: pending = driven, captured = taken at the last rising edge
  logic [7:0] p_d, c_d;
  logic       p_en, p_er, c_en, c_er;
  // receive model: inflight = being driven this cycle, last = previous cycle, exp = now on outputs
  logic [7:0] i_d, l_d, e_d;
  logic       i_dv, i_er, l_dv, l_er, e_dv, e_er;

  initial begin
    rst = 1'b1; txd = '0; tx_en = 0; tx_er = 0; r_rxd = '0; r_rxctl = 0;
    p_d = '0; p_en = 0; p_er = 0; c_d = '0; c_en = 0; c_er = 0;
    i_d = '0; i_dv = 0; i_er = 0; l_d = '0; l_dv = 0; l_er = 0;
    e_d = '0; e_dv = 0; e_er = 0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "tx nibble high", 16'(r_txd), 16'h0);
    chk("R1", "tx ctl high", 16'(r_txctl), 16'h0);
    chk("R1", "rx byte", 16'(rxd), 16'h0);
    chk("R1", "rx dv", 16'(rx_dv), 16'h0);
    chk("R1", "rx er", 16'(rx_er), 16'h0);
    #10;
    chk("R1", "tx nibble low", 16'(r_txd), 16'h0);
    chk("R1", "tx ctl low", 16'(r_txctl), 16'h0);
    #2 rst = 1'b0;

    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      #1;
      c_d = p_d; c_en = p_en; c_er = p_er;
      e_d = l_d; e_dv = l_dv; e_er = l_er;
      l_d = i_d; l_dv = i_dv; l_er = i_er;
      #1;
      p_d = 8'($urandom);
      if (c < 100)      begin p_en = 1'b1; p_er = 1'b0; end
      else if (c < 200) begin p_en = 1'b0; p_er = 1'($urandom); end
      else if (c < 300) begin p_en = 1'b1; p_er = 1'($urandom); end
      else              begin p_en = ($urandom % 4) != 0; p_er = ($urandom % 5) == 0; end
      if (c == 10) p_d = 8'hA5;
      if (c == 11) p_d = 8'h0F;
      txd = p_d; tx_en = p_en; tx_er = p_er;
      #3;
      // high phase
      chk("R7", "txc high", 16'(txc), 16'h1);
      if (c_en) begin
        chk("R2", "tx low nibble", 16'(r_txd), 16'(c_d[3:0]));
        chk("R4", "tx ctl first", 16'(r_txctl), 16'h1);
      end else begin
        chk("R6", "idle nibble first", 16'(r_txd), 16'h0);
        chk("R6", "idle ctl first", 16'(r_txctl), 16'h0);
      end
      chk("R8", "rx byte", 16'(rxd), 16'(e_d));
      chk("R9", "rx dv", 16'(rx_dv), 16'(e_dv));
      chk("R10", "rx er", 16'(rx_er), 16'(e_er));
      r_rxd = i_d[7:4]; r_rxctl = i_dv ^ i_er;
      #10;
      // low phase
      chk("R7", "txc low", 16'(txc), 16'h0);
      if (c_en) begin
        chk("R3", "tx high nibble", 16'(r_txd), 16'(c_d[7:4]));
        chk("R5", "tx ctl second", 16'(r_txctl), 16'(!c_er));
      end else begin
        chk("R6", "idle nibble second", 16'(r_txd), 16'h0);
        chk("R6", "idle ctl second", 16'(r_txctl), 16'h0);
      end
      i_d = 8'($urandom);
      if (c < 100)      begin i_dv = 1'b1; i_er = 1'b0; end
      else if (c < 200) begin i_dv = 1'b0; i_er = 1'($urandom); end
      else if (c < 300) begin i_dv = 1'b1; i_er = 1'($urandom); end
      else              begin i_dv = 1'($urandom); i_er = ($urandom % 4) == 0; end
      if (c == 20) i_d = 8'h5A;
      r_rxd = i_d[3:0]; r_rxctl = i_dv;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #((NCYC + 50) * 20 * 2);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule